// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a 12-bit successive-approximation converter that talks over three wires: an active-low select line that also powers the converter down while high, a data clock driven by the host, and a serial data line driven back by the converter. A single-cycle start request pulls the select line low and begins toggling the data clock, which is derived from the system clock by a parameterised divider. The converter spends a configurable number of data-clock cycles sampling and converting, then presents one null bit and the twelve result bits, most significant first. The controller samples the data line on each rising data-clock edge, throws away the preamble and the null bit, and shifts the result into a word register.

After the last result bit the controller either ends the frame at once or, when echo mode was requested at start, keeps clocking to collect the least-significant-first repeat of the word and flags any disagreement with the first copy. At the end of the frame the select line goes high, the data clock parks low, and the word appears with a one-cycle valid strobe. The select line then stays high for a guard interval before a new request is accepted.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0 and valid is 0.
- R2: A start seen while busy is 0 makes cs_n 0 and busy 1 on the next clock; sclk is 0 whenever cs_n is 1.
- R3: While cs_n is 0, every low and every high phase of sclk lasts exactly HALF_DIV system clocks, the first low phase counting from the fall of cs_n.
- R4: Rising sclk edges numbered 0 to PRE_CYC (preamble and null bit) are ignored; edges PRE_CYC+1 to PRE_CYC+12 carry the result, the first of them being bit 11 of data.
- R5: With echo mode off, the frame has exactly PRE_CYC+13 rising sclk edges, and mismatch is 0 with the result.
- R6: With echo mode on, the frame has exactly PRE_CYC+24 rising sclk edges; the 11 extra edges carry word bits 1 to 11 in that order, and mismatch is 1 exactly when one of them differs from the captured word.
- R7: valid is a one-cycle pulse in the cycle cs_n returns to 1, with data and mismatch holding the frame result; there is exactly one valid per accepted start.
- R8: A start request while busy is 1 is ignored and does not alter the frame in progress.
- R9: cs_n stays 1 for at least GAP_CYC+1 system clocks between frames; with start held high it stays 1 for exactly GAP_CYC+1.
- R10: echo_en is taken only in the cycle a start is accepted; changes during a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one conversion frame |
| echo_en | input | 1 | Collect and check the LSB-first repeat in this frame |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low select / power-down to the converter |
| sclk | output | 1 | Data clock to the converter |
| busy | output | 1 | Frame or guard interval in progress |
| valid | output | 1 | One-cycle strobe: data and mismatch hold a new result |
| data | output | 12 | Captured result word |
| mismatch | output | 1 | Echo bits disagreed with the word |

## Verification
The hardest situation to reach is the guard interval under a continuously asserted start, since any request arriving during a frame or during the guard must be swallowed and yet the next frame must begin on the very first idle cycle. The bench holds start high across an entire frame and its guard, then measures the select-high time exactly and checks that only two results come out. Echo disagreements are produced by a converter model that flips chosen bits of its repeat, including the least significant bit, which is never resent and so must not raise the flag.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } rd_state_e;

endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_done
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        half_done = run && (cnt_q == LAST);
        if (!run || half_done) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_rd_cap.sv
module adc_rd_cap #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              dat_en,
    input  logic              ech_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word,
    output logic              mism
);
    localparam int IW = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [IW-1:0]     idx;
        logic              mism;
    } cap_t;

    cap_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.word = '0;
            r_d.idx  = IW'(1);
            r_d.mism = 1'b0;
        end else if (dat_en) begin
            r_d.word = {r_q.word[WORD_W-2:0], bit_in};
        end else if (ech_en) begin
            if (bit_in != r_q.word[r_q.idx]) begin
                r_d.mism = 1'b1;
            end
            r_d.idx = r_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word = r_q.word;
    assign mism = r_q.mism;
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int WORD_W   = 12,
    parameter int HALF_DIV = 4,
    parameter int PRE_CYC  = 2,
    parameter int GAP_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              echo_en,
    input  logic              sdi,
    output logic              cs_n,
    output logic              sclk,
    output logic              busy,
    output logic              valid,
    output logic [WORD_W-1:0] data,
    output logic              mismatch
);
    localparam int N_PLAIN_I = PRE_CYC + 1 + WORD_W;
    localparam int N_ECHO_I  = PRE_CYC + 2 * WORD_W;
    localparam int EW        = $clog2(N_ECHO_I + 1);
    localparam int GW        = $clog2(GAP_CYC + 1);
    localparam logic [EW-1:0] K_FIRST = EW'(PRE_CYC + 1);
    localparam logic [EW-1:0] K_LAST  = EW'(PRE_CYC + WORD_W);
    localparam logic [EW-1:0] N_PLAIN = EW'(N_PLAIN_I);
    localparam logic [EW-1:0] N_ECHO  = EW'(N_ECHO_I);
    localparam logic [GW-1:0] G_LAST  = GW'(GAP_CYC - 1);

    typedef struct packed {
        rd_state_e     st;
        logic          cs_n;
        logic          sclk;
        logic [EW-1:0] edge_cnt;
        logic          echo;
        logic [GW-1:0] gap_cnt;
        logic          valid;
    } ctl_t;

    ctl_t r_q, r_d;
    logic half_done;
    logic cap_clr, dat_en, ech_en;

    adc_rd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (r_q.st == ST_RUN),
        .half_done (half_done)
    );

    adc_rd_cap #(.WORD_W(WORD_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cap_clr),
        .dat_en (dat_en),
        .ech_en (ech_en),
        .bit_in (sdi),
        .word   (data),
        .mism   (mismatch)
    );

    always_comb begin
        r_d     = r_q;
        r_d.valid = 1'b0;
        cap_clr = 1'b0;
        dat_en  = 1'b0;
        ech_en  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st       = ST_RUN;
                    r_d.cs_n     = 1'b0;
                    r_d.sclk     = 1'b0;
                    r_d.edge_cnt = '0;
                    r_d.echo     = echo_en;
                    cap_clr      = 1'b1;
                end
            end
            ST_RUN: begin
                if (half_done) begin
                    if (!r_q.sclk) begin
                        r_d.sclk     = 1'b1;
                        r_d.edge_cnt = r_q.edge_cnt + 1'b1;
                        if (r_q.edge_cnt >= K_FIRST && r_q.edge_cnt <= K_LAST) begin
                            dat_en = 1'b1;
                        end else if (r_q.echo && r_q.edge_cnt > K_LAST) begin
                            ech_en = 1'b1;
                        end
                    end else if (r_q.edge_cnt == (r_q.echo ? N_ECHO : N_PLAIN)) begin
                        r_d.st      = ST_GAP;
                        r_d.cs_n    = 1'b1;
                        r_d.sclk    = 1'b0;
                        r_d.valid   = 1'b1;
                        r_d.gap_cnt = '0;
                    end else begin
                        r_d.sclk = 1'b0;
                    end
                end
            end
            ST_GAP: begin
                if (r_q.gap_cnt == G_LAST) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.gap_cnt = r_q.gap_cnt + 1'b1;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.cs_n = 1'b1;
                r_d.sclk = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n  = r_q.cs_n;
    assign sclk  = r_q.sclk;
    assign busy  = (r_q.st != ST_IDLE);
    assign valid = r_q.valid;
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
    parameter int HALF_DIV = 4,
    parameter int GAP_CYC  = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic cs_n,
    input logic sclk,
    input logic valid
);
    localparam int HW = $clog2(HALF_DIV + 2) + 1;
    localparam int CW = $clog2(GAP_CYC + 2) + 1;
    localparam logic [HW-1:0] HALF_V = HW'(HALF_DIV);
    localparam logic [CW-1:0] CS_SAT = CW'(GAP_CYC + 1);

    logic [HW-1:0] hi_cnt;
    logic [CW-1:0] cs_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            cs_hi  <= CS_SAT;
        end else begin
            hi_cnt <= sclk ? hi_cnt + 1'b1 : '0;
            if (!cs_n) begin
                cs_hi <= '0;
            end else if (cs_hi != CS_SAT) begin
                cs_hi <= cs_hi + 1'b1;
            end
        end
    end

    a_r2_sclk_parked: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!cs_n && busy));

    a_r3_high_half: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_cnt == HALF_V));

    a_r7_valid_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $rose(cs_n));

    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r9_guard_time: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (cs_hi == CS_SAT));
endmodule

bind adc_rd_ctrl adc_rd_chk #(
    .HALF_DIV (HALF_DIV),
    .GAP_CYC  (GAP_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .valid (valid)
);

// File: tb/sim_adc_rd_ctrl.sv
module sim_adc_rd_ctrl;
    localparam int W    = 12;
    localparam int HALF = 4;
    localparam int PRE  = 2;
    localparam int GAP  = 8;
    localparam int E_PLAIN = PRE + 1 + W;
    localparam int E_ECHO  = PRE + 2 * W;

    typedef struct {
        logic [W-1:0] data;
        logic         mism;
        int           edges;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic echo_en = 1'b0;
    logic sdi = 1'b1;
    logic cs_n, sclk, busy, valid, mismatch;
    logic [W-1:0] data;

    adc_rd_ctrl #(.WORD_W(W), .HALF_DIV(HALF), .PRE_CYC(PRE), .GAP_CYC(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .echo_en(echo_en), .sdi(sdi),
        .cs_n(cs_n), .sclk(sclk), .busy(busy), .valid(valid), .data(data),
        .mismatch(mismatch)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    int n_push = 0;
    int n_valid = 0;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // converter model state
    logic [W-1:0] m_word = '0, m_echo = '0;
    logic [W-1:0] lw, le;
    int m_k = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;
    int edges = 0, run_len = 0, hi_run = 1000, last_hi = 0;
    bit tim_bad = 1'b0;
    bit gap_probe = 1'b0;

    function automatic logic bitf(input int k);
        int j;
        if (k < PRE) return 1'b1;
        if (k == PRE) return 1'b0;
        if (k - PRE - 1 < W) return lw[W - 1 - (k - PRE - 1)];
        j = k - PRE - W;
        if (j >= 1 && j < W) return le[j];
        return 1'b0;
    endfunction

    // model, measurement and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                if (gap_probe) begin
                    chk(hi_run == GAP + 1, "R9 guard with start held", hi_run, GAP + 1);
                    gap_probe = 1'b0;
                end
                chk(hi_run >= GAP + 1, "R9 guard minimum", hi_run, GAP + 1);
                lw = m_word; le = m_echo;
                m_k = 0; sdi = bitf(0);
                edges = 0; run_len = 1; tim_bad = 1'b0;
            end else if (!cs_n) begin
                if (sclk != prev_sclk) begin
                    if (run_len != HALF) tim_bad = 1'b1;
                    run_len = 1;
                    if (sclk) edges++;
                    else begin m_k++; sdi = bitf(m_k); end
                end else run_len++;
            end else if (!prev_cs && cs_n) begin
                if (run_len != HALF) tim_bad = 1'b1;
            end
            hi_run = cs_n ? hi_run + 1 : 0;
            if (valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(data == e.data, "R4 data word", data, e.data);
                    chk(mismatch == e.mism, "R6 mismatch flag", mismatch, e.mism);
                    chk(edges == e.edges, (e.edges == E_ECHO) ? "R6 echo edge count" : "R5 edge count",
                        edges, e.edges);
                    chk(!tim_bad, "R3 sclk phase length", tim_bad, 0);
                    chk(cs_n && !sclk, "R7 close state", {cs_n, sclk}, 2);
                end
            end
            prev_sclk = sclk;
            prev_cs = cs_n;
        end
    end

    // watchdog
    int wd = 0;
    always @(negedge clk) begin
        wd++;
        if (wd > 150000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic push(input logic [W-1:0] w, input bit ech, input logic [W-1:0] flip);
        exp_t e;
        e.data = w;
        e.mism = ech && (flip[W-1:1] != '0);
        e.edges = ech ? E_ECHO : E_PLAIN;
        exp_q.push_back(e);
        n_push++;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic conv(input logic [W-1:0] w, input bit ech, input logic [W-1:0] flip);
        wait_idle();
        m_word = w; m_echo = w ^ flip;
        echo_en = ech;
        start = 1'b1;
        push(w, ech, flip);
        @(negedge clk);
        start = 1'b0;
        chk(!cs_n && busy, "R2 start opens frame", {cs_n, busy}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk reset", sclk, 0);
        chk(busy == 1'b0 && valid == 1'b0, "R1 busy valid reset", {busy, valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n && !sclk && !busy, "R1 idle after release", {cs_n, sclk, busy}, 4);

        // R4 R5 plain frames
        conv(12'hA5C, 1'b0, '0);
        conv(12'h000, 1'b0, '0);
        conv(12'hFFF, 1'b0, '0);
        conv(12'h801, 1'b0, '0);

        // R6 echo frames
        conv(12'h3C6, 1'b1, '0);
        conv(12'h3C6, 1'b1, 12'h800);
        conv(12'h555, 1'b1, 12'h002);
        conv(12'h555, 1'b1, 12'h001);

        // R10 echo_en flipped mid-frame
        conv(12'h9A7, 1'b1, '0);
        repeat (20) @(negedge clk);
        echo_en = 1'b0;
        conv(12'h1E3, 1'b0, '0);
        repeat (20) @(negedge clk);
        echo_en = 1'b1;

        // R8 start pulse while busy
        conv(12'h6B2, 1'b0, '0);
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;

        // R8 R9 start held across a frame and its guard
        wait_idle();
        m_word = 12'hC39; m_echo = 12'hC39;
        echo_en = 1'b0;
        push(12'hC39, 1'b0, '0);
        start = 1'b1;
        @(negedge clk);
        chk(!cs_n && busy, "R2 held start opens frame", {cs_n, busy}, 1);
        while (!valid) @(negedge clk);
        m_word = 12'h4D0; m_echo = 12'h4D0;
        push(12'h4D0, 1'b0, '0);
        gap_probe = 1'b1;
        while (cs_n) @(negedge clk);
        start = 1'b0;

        wait_idle();
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R7 all results seen", exp_q.size(), 0);
        chk(n_valid == n_push, "R8 one valid per accepted start", n_valid, n_push);
        chk(cs_n && !busy, "R8 no stray frame", {cs_n, busy}, 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule